// File: doc/BRIEF.md
# Trap Entry State Sequencer

This block computes and commits the architectural state change a processor core makes when it takes a trap. It does not fetch the handler. A trap request arrives with an 8-bit trap type, two mode selects (recovery-mode entry and hyperprivileged entry) and the core's current state fields. These fields are trap level, processor state, hypervisor state, condition codes, address-space identifier, register-window pointer, free-window count, global level, PC and next PC. One clock later the block presents the new values of those registers. It also presents the words to be pushed onto the trap stack, a write-enable vector for the trap-stack entries and a one-cycle done pulse.

A separate power-on request loads the defined start-up values. These are maximum trap level, maximum global level, a fixed processor-state word, recovery and hyperprivilege flags in the hypervisor state, and a sticky lock flag for the cycle counter. The surrounding core owns the register file and the trap-stack storage. It writes the outputs into them when done or the enables say so.

Top module: `trap_entry_seq`

## Requirements
- R1: One cycle after a trap request (with power-on request low), done is high for exactly one cycle and the new trap level equals the current trap level plus one; done stays low in every other cycle.
- R2: When bit 3 of the current processor state is set, the saved PC and next PC keep only their low 32 bits (upper bits zero); otherwise they are saved unchanged.
- R3: The saved state word is 43 bits. It places the global level in bits 42:40, the condition codes in 39:32 and the address-space identifier in 31:24. The 13-bit processor state goes in bits 20:8 and the window pointer, zero-extended, in bits 4:0. Bits 23:21 and 7:5 are zero. All fields are pre-trap values.
- R4: On commit, the saved hypervisor word equals the pre-trap hypervisor state and the saved trap type equals the request's type. All five trap-stack write enables (bit 0 state word, 1 PC, 2 next PC, 3 hypervisor word, 4 trap type) are high in the done cycle only.
- R5: Recovery-mode entry (recovery select high, which overrides the hyperprivileged select) keeps only bit 2 of the processor state and then sets bit 4. In the hypervisor state it sets bits 5 and 2, clears bits 10 and 0, and keeps the other bits.
- R6: Hyperprivileged entry sets processor-state bit 4 and clears bits 3, 1 and 9, leaving the other bits. In the hypervisor state it clears bits 5 and 10, sets bit 2, and keeps bit 0 and the rest.
- R7: Privileged entry (both selects low) sets processor-state bits 4 and 2, clears bits 3 and 1, and copies bit 8 into bit 9. The hypervisor state is unchanged.
- R8: The new global level is the current level plus one, saturated at GL_MAX_PRIV (default 2) for privileged entry and at GL_MAX_HYP (default 3) for recovery and hyperprivileged entry.
- R9: Trap type 0x24 adds one to the window pointer. Types 0x80 to 0xBF add the free-window count plus two, and types 0xC0 to 0xFF subtract one. All results are taken modulo NWIN (default 8), and the window write enable is then high. Any other type leaves the pointer unchanged with the window write enable low.
- R10: A power-on request has priority over a trap. One cycle later the trap level is TL_MAX (default 6), the global level is GL_MAX_HYP and the processor state is 0x014. The hypervisor state is the current one with bits 5 and 2 set and bits 10 and 0 cleared. The counter-lock flag is set and stays set until reset. Done and all write enables are low.
- R11: Synchronous active-high reset clears every output register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| por_req | input | 1 | Power-on state load request |
| trap_req | input | 1 | Trap entry request |
| trap_type | input | 8 | Trap type code |
| sel_recover | input | 1 | Enter recovery mode |
| sel_hyp | input | 1 | Enter hyperprivileged mode |
| cur_tl | input | TL_W | Current trap level |
| cur_ps | input | 13 | Current processor state |
| cur_hs | input | 11 | Current hypervisor state |
| cur_cc | input | 8 | Current condition codes |
| cur_asi | input | 8 | Current address-space identifier |
| cur_win | input | WIN_W | Current window pointer |
| cur_free | input | WIN_W | Free-window count |
| cur_gl | input | GL_W | Current global level |
| cur_pc | input | ADDR_W | Current PC |
| cur_npc | input | ADDR_W | Current next PC |
| done | output | 1 | Commit pulse |
| new_tl | output | TL_W | New trap level |
| new_ps | output | 13 | New processor state |
| new_hs | output | 11 | New hypervisor state |
| new_gl | output | GL_W | New global level |
| new_win | output | WIN_W | New window pointer |
| win_we | output | 1 | Window pointer write enable |
| stk_word | output | 43 | Saved state word |
| stk_pc | output | ADDR_W | Saved PC |
| stk_npc | output | ADDR_W | Saved next PC |
| stk_hs | output | 11 | Saved hypervisor state |
| stk_tt | output | 8 | Saved trap type |
| stk_we | output | 5 | Trap-stack write enables |
| tick_lock | output | 1 | Cycle-counter lock flag |

## Verification
The assertions check, on every cycle, the timing of done against the request and the trap-level increment. They also check that the write-enable vector agrees with done, that the pre-trap hypervisor word is saved, and that the recovery flags are set. They further check that the global level never exceeds its cap, that the window pointer stays in range, and the power-on values. Only the bench scenarios can show the exact rewritten state words for each mode, the bit packing of the saved word, and address masking. They also cover each window-shift range, including wraparound in both directions, saturation against the lower privileged cap, and a power-on request that collides with a trap.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;

    localparam int PS_W     = 13;
    localparam int HS_W     = 11;
    localparam int CC_W     = 8;
    localparam int ASI_W    = 8;
    localparam int TT_W     = 8;
    localparam int SV_GL_W  = 3;
    localparam int SV_WIN_W = 5;
    localparam int SAVE_W   = SV_GL_W + CC_W + ASI_W + 3 + PS_W + 3 + SV_WIN_W;
    localparam int STK_N    = 5;

    // processor state bit positions
    localparam int PS_IE   = 1;
    localparam int PS_PRIV = 2;
    localparam int PS_AM   = 3;
    localparam int PS_PEF  = 4;
    localparam int PS_TLE  = 8;
    localparam int PS_CLE  = 9;

    // hypervisor state bit positions
    localparam int HS_TLZ   = 0;
    localparam int HS_HPRIV = 2;
    localparam int HS_RCV   = 5;
    localparam int HS_IBE   = 10;

    // trap-stack write-enable lanes
    localparam int STK_WORD = 0;
    localparam int STK_PC   = 1;
    localparam int STK_NPC  = 2;
    localparam int STK_HS   = 3;
    localparam int STK_TT   = 4;

    typedef enum logic [1:0] {
        EM_RECOVER = 2'd0,
        EM_HYP     = 2'd1,
        EM_PRIV    = 2'd2
    } entry_mode_e;

    typedef struct packed {
        logic [PS_W-1:0] ps;
        logic [HS_W-1:0] hs;
    } mode_state_t;

    function automatic entry_mode_e pick_mode(input logic rec, input logic hyp);
        if (rec)
            return EM_RECOVER;
        else if (hyp)
            return EM_HYP;
        return EM_PRIV;
    endfunction

    function automatic logic [HS_W-1:0] force_recover_hs(input logic [HS_W-1:0] hs);
        logic [HS_W-1:0] r;
        r = hs;
        r[HS_RCV]   = 1'b1;
        r[HS_HPRIV] = 1'b1;
        r[HS_IBE]   = 1'b0;
        r[HS_TLZ]   = 1'b0;
        return r;
    endfunction

    function automatic mode_state_t rewrite_state(input entry_mode_e m,
                                                  input logic [PS_W-1:0] ps,
                                                  input logic [HS_W-1:0] hs);
        mode_state_t r;
        r.ps = ps;
        r.hs = hs;
        case (m)
            EM_RECOVER: begin
                r.ps          = '0;
                r.ps[PS_PRIV] = ps[PS_PRIV];
                r.ps[PS_PEF]  = 1'b1;
                r.hs          = force_recover_hs(hs);
            end
            EM_HYP: begin
                r.ps[PS_PEF]  = 1'b1;
                r.ps[PS_AM]   = 1'b0;
                r.ps[PS_IE]   = 1'b0;
                r.ps[PS_CLE]  = 1'b0;
                r.hs[HS_RCV]   = 1'b0;
                r.hs[HS_HPRIV] = 1'b1;
                r.hs[HS_IBE]   = 1'b0;
            end
            default: begin
                r.ps[PS_PEF]  = 1'b1;
                r.ps[PS_AM]   = 1'b0;
                r.ps[PS_IE]   = 1'b0;
                r.ps[PS_PRIV] = 1'b1;
                r.ps[PS_CLE]  = ps[PS_TLE];
            end
        endcase
        return r;
    endfunction

    function automatic logic [SAVE_W-1:0] pack_saved(input logic [SV_GL_W-1:0]  gl,
                                                     input logic [CC_W-1:0]     cc,
                                                     input logic [ASI_W-1:0]    asi,
                                                     input logic [PS_W-1:0]     ps,
                                                     input logic [SV_WIN_W-1:0] win);
        return {gl, cc, asi, 3'b000, ps, 3'b000, win};
    endfunction

endpackage

// File: rtl/trap_save_pack.sv
module trap_save_pack
    import trap_entry_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int GL_W   = 3,
    parameter int WIN_W  = 3
) (
    input  logic [GL_W-1:0]   gl,
    input  logic [CC_W-1:0]   cc,
    input  logic [ASI_W-1:0]  asi,
    input  logic [PS_W-1:0]   ps,
    input  logic [WIN_W-1:0]  win,
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] npc,
    output logic [SAVE_W-1:0] word,
    output logic [ADDR_W-1:0] pc_sv,
    output logic [ADDR_W-1:0] npc_sv
);
    localparam int LOW_W = (ADDR_W < 32) ? ADDR_W : 32;

    logic [ADDR_W-1:0] keep_mask;
    logic [SV_WIN_W-1:0] win_ext;
    logic [SV_GL_W-1:0]  gl_fit;

    always_comb begin
        keep_mask = '1;
        if (ps[PS_AM])
            keep_mask = {{(ADDR_W-LOW_W){1'b0}}, {LOW_W{1'b1}}};
    end

    assign win_ext = SV_WIN_W'(win);
    assign gl_fit  = SV_GL_W'(gl);
    assign pc_sv   = pc & keep_mask;
    assign npc_sv  = npc & keep_mask;
    assign word    = pack_saved(gl_fit, cc, asi, ps, win_ext);
endmodule

// File: rtl/trap_state_rewrite.sv
module trap_state_rewrite
    import trap_entry_pkg::*;
#(
    parameter int GL_W        = 3,
    parameter int GL_MAX_HYP  = 3,
    parameter int GL_MAX_PRIV = 2
) (
    input  entry_mode_e     mode,
    input  logic [PS_W-1:0] ps,
    input  logic [HS_W-1:0] hs,
    input  logic [GL_W-1:0] gl,
    output mode_state_t     st,
    output logic [GL_W-1:0] gl_nxt
);
    localparam logic [GL_W:0] CAP_HYP  = (GL_W+1)'(GL_MAX_HYP);
    localparam logic [GL_W:0] CAP_PRIV = (GL_W+1)'(GL_MAX_PRIV);

    logic [GL_W:0] gl_inc;
    logic [GL_W:0] gl_cap;

    assign st     = rewrite_state(mode, ps, hs);
    assign gl_inc = {1'b0, gl} + 1'b1;
    assign gl_cap = (mode == EM_PRIV) ? CAP_PRIV : CAP_HYP;

    always_comb begin
        if (gl_inc > gl_cap)
            gl_nxt = gl_cap[GL_W-1:0];
        else
            gl_nxt = gl_inc[GL_W-1:0];
    end
endmodule

// File: rtl/trap_win_shift.sv
module trap_win_shift
    import trap_entry_pkg::*;
#(
    parameter int NWIN  = 8,
    parameter int WIN_W = 3
) (
    input  logic [TT_W-1:0]  tt,
    input  logic [WIN_W-1:0] win,
    input  logic [WIN_W-1:0] free,
    output logic [WIN_W-1:0] win_nxt,
    output logic             moved
);
    localparam int SUM_W = WIN_W + 2;
    localparam logic [SUM_W-1:0] NW = SUM_W'(NWIN);

    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] wrapped;

    always_comb begin
        moved = 1'b1;
        sum   = SUM_W'(win);
        if (tt == 8'h24)
            sum = SUM_W'(win) + SUM_W'(1);
        else if (tt[7:6] == 2'b10)
            sum = SUM_W'(win) + SUM_W'(free) + SUM_W'(2);
        else if (tt[7:6] == 2'b11)
            sum = SUM_W'(win) + NW - SUM_W'(1);
        else
            moved = 1'b0;
    end

    assign wrapped = sum % NW;
    assign win_nxt = wrapped[WIN_W-1:0];
endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
    import trap_entry_pkg::*;
#(
    parameter int ADDR_W      = 64,
    parameter int TL_W        = 3,
    parameter int TL_MAX      = 6,
    parameter int GL_W        = 3,
    parameter int GL_MAX_HYP  = 3,
    parameter int GL_MAX_PRIV = 2,
    parameter int NWIN        = 8,
    parameter int WIN_W       = $clog2(NWIN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              por_req,
    input  logic              trap_req,
    input  logic [7:0]        trap_type,
    input  logic              sel_recover,
    input  logic              sel_hyp,
    input  logic [TL_W-1:0]   cur_tl,
    input  logic [12:0]       cur_ps,
    input  logic [10:0]       cur_hs,
    input  logic [7:0]        cur_cc,
    input  logic [7:0]        cur_asi,
    input  logic [WIN_W-1:0]  cur_win,
    input  logic [WIN_W-1:0]  cur_free,
    input  logic [GL_W-1:0]   cur_gl,
    input  logic [ADDR_W-1:0] cur_pc,
    input  logic [ADDR_W-1:0] cur_npc,
    output logic              done,
    output logic [TL_W-1:0]   new_tl,
    output logic [12:0]       new_ps,
    output logic [10:0]       new_hs,
    output logic [GL_W-1:0]   new_gl,
    output logic [WIN_W-1:0]  new_win,
    output logic              win_we,
    output logic [42:0]       stk_word,
    output logic [ADDR_W-1:0] stk_pc,
    output logic [ADDR_W-1:0] stk_npc,
    output logic [10:0]       stk_hs,
    output logic [7:0]        stk_tt,
    output logic [4:0]        stk_we,
    output logic              tick_lock
);
    localparam logic [TL_W-1:0] TL_TOP  = TL_W'(TL_MAX);
    localparam logic [GL_W-1:0] GL_TOP  = GL_W'(GL_MAX_HYP);
    localparam logic [PS_W-1:0] PS_BOOT = PS_W'((1 << PS_PEF) | (1 << PS_PRIV));

    entry_mode_e       mode;
    mode_state_t       st_nxt;
    logic [GL_W-1:0]   gl_nxt;
    logic [WIN_W-1:0]  win_nxt;
    logic              win_moved;
    logic [SAVE_W-1:0] word_nxt;
    logic [ADDR_W-1:0] pc_sv;
    logic [ADDR_W-1:0] npc_sv;
    logic              take;

    assign mode = pick_mode(sel_recover, sel_hyp);
    assign take = trap_req && !por_req;

    trap_state_rewrite #(
        .GL_W        (GL_W),
        .GL_MAX_HYP  (GL_MAX_HYP),
        .GL_MAX_PRIV (GL_MAX_PRIV)
    ) u_rewrite (
        .mode   (mode),
        .ps     (cur_ps),
        .hs     (cur_hs),
        .gl     (cur_gl),
        .st     (st_nxt),
        .gl_nxt (gl_nxt)
    );

    trap_win_shift #(
        .NWIN  (NWIN),
        .WIN_W (WIN_W)
    ) u_win (
        .tt      (trap_type),
        .win     (cur_win),
        .free    (cur_free),
        .win_nxt (win_nxt),
        .moved   (win_moved)
    );

    trap_save_pack #(
        .ADDR_W (ADDR_W),
        .GL_W   (GL_W),
        .WIN_W  (WIN_W)
    ) u_pack (
        .gl     (cur_gl),
        .cc     (cur_cc),
        .asi    (cur_asi),
        .ps     (cur_ps),
        .win    (cur_win),
        .pc     (cur_pc),
        .npc    (cur_npc),
        .word   (word_nxt),
        .pc_sv  (pc_sv),
        .npc_sv (npc_sv)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done      <= 1'b0;
            new_tl    <= '0;
            new_ps    <= '0;
            new_hs    <= '0;
            new_gl    <= '0;
            new_win   <= '0;
            win_we    <= 1'b0;
            stk_word  <= '0;
            stk_pc    <= '0;
            stk_npc   <= '0;
            stk_hs    <= '0;
            stk_tt    <= '0;
            stk_we    <= '0;
            tick_lock <= 1'b0;
        end else begin
            done   <= 1'b0;
            win_we <= 1'b0;
            stk_we <= '0;
            if (por_req) begin
                new_tl    <= TL_TOP;
                new_gl    <= GL_TOP;
                new_ps    <= PS_BOOT;
                new_hs    <= force_recover_hs(cur_hs);
                tick_lock <= 1'b1;
            end else if (take) begin
                done     <= 1'b1;
                new_tl   <= cur_tl + 1'b1;
                new_ps   <= st_nxt.ps;
                new_hs   <= st_nxt.hs;
                new_gl   <= gl_nxt;
                new_win  <= win_moved ? win_nxt : cur_win;
                win_we   <= win_moved;
                stk_word <= word_nxt;
                stk_pc   <= pc_sv;
                stk_npc  <= npc_sv;
                stk_hs   <= cur_hs;
                stk_tt   <= trap_type;
                stk_we   <= '1;
            end
        end
    end
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk #(
    parameter int ADDR_W      = 64,
    parameter int TL_W        = 3,
    parameter int TL_MAX      = 6,
    parameter int GL_W        = 3,
    parameter int GL_MAX_HYP  = 3,
    parameter int GL_MAX_PRIV = 2,
    parameter int NWIN        = 8,
    parameter int WIN_W       = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              por_req,
    input logic              trap_req,
    input logic              sel_recover,
    input logic [TL_W-1:0]   cur_tl,
    input logic [10:0]       cur_hs,
    input logic              done,
    input logic [TL_W-1:0]   new_tl,
    input logic [10:0]       new_hs,
    input logic [GL_W-1:0]   new_gl,
    input logic [WIN_W-1:0]  new_win,
    input logic [10:0]       stk_hs,
    input logic [4:0]        stk_we,
    input logic              tick_lock
);
    AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        (trap_req && !por_req) |=> done) else $error("AST_DONE_AFTER_REQ"); // R1
    AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (rst)
        !(trap_req && !por_req) |=> !done) else $error("AST_NO_SPURIOUS_DONE"); // R1
    AST_TL_STEP: assert property (@(posedge clk) disable iff (rst)
        (trap_req && !por_req) |=> new_tl == TL_W'($past(cur_tl) + 1'b1)) else $error("AST_TL_STEP"); // R1
    AST_WE_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        done |-> stk_we == 5'h1f) else $error("AST_WE_WITH_DONE"); // R4
    AST_WE_IDLE: assert property (@(posedge clk) disable iff (rst)
        !done |-> stk_we == 5'h00) else $error("AST_WE_IDLE"); // R4
    AST_HS_SAVED: assert property (@(posedge clk) disable iff (rst)
        (trap_req && !por_req) |=> stk_hs == $past(cur_hs)) else $error("AST_HS_SAVED"); // R4
    AST_RECOVER_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (trap_req && !por_req && sel_recover) |=> (new_hs[5] && new_hs[2] && !new_hs[10] && !new_hs[0])) else $error("AST_RECOVER_FLAGS"); // R5
    AST_GL_CAP: assert property (@(posedge clk) disable iff (rst)
        done |-> new_gl <= GL_W'(GL_MAX_HYP)) else $error("AST_GL_CAP"); // R8
    AST_WIN_RANGE: assert property (@(posedge clk) disable iff (rst)
        done |-> int'(new_win) < NWIN) else $error("AST_WIN_RANGE"); // R9
    AST_POR_LOAD: assert property (@(posedge clk) disable iff (rst)
        por_req |=> (new_tl == TL_W'(TL_MAX) && new_gl == GL_W'(GL_MAX_HYP) && tick_lock && !done)) else $error("AST_POR_LOAD"); // R10
endmodule

bind trap_entry_seq trap_entry_chk #(
    .ADDR_W      (ADDR_W),
    .TL_W        (TL_W),
    .TL_MAX      (TL_MAX),
    .GL_W        (GL_W),
    .GL_MAX_HYP  (GL_MAX_HYP),
    .GL_MAX_PRIV (GL_MAX_PRIV),
    .NWIN        (NWIN),
    .WIN_W       (WIN_W)
) u_chk (.*);

// File: tb/trap_entry_seq_bench.sv
module trap_entry_seq_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        por_req;
    logic        trap_req;
    logic [7:0]  trap_type;
    logic        sel_recover;
    logic        sel_hyp;
    logic [2:0]  cur_tl;
    logic [12:0] cur_ps;
    logic [10:0] cur_hs;
    logic [7:0]  cur_cc;
    logic [7:0]  cur_asi;
    logic [2:0]  cur_win;
    logic [2:0]  cur_free;
    logic [2:0]  cur_gl;
    logic [63:0] cur_pc;
    logic [63:0] cur_npc;
    logic        done;
    logic [2:0]  new_tl;
    logic [12:0] new_ps;
    logic [10:0] new_hs;
    logic [2:0]  new_gl;
    logic [2:0]  new_win;
    logic        win_we;
    logic [42:0] stk_word;
    logic [63:0] stk_pc;
    logic [63:0] stk_npc;
    logic [10:0] stk_hs;
    logic [7:0]  stk_tt;
    logic [4:0]  stk_we;
    logic        tick_lock;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    trap_entry_seq u_trap_entry_seq (.*);

    typedef struct packed {
        logic [2:0]  tl;
        logic [12:0] ps;
        logic [10:0] hs;
        logic [2:0]  gl;
        logic [2:0]  win;
        logic        wwe;
        logic [42:0] word;
        logic [63:0] pc;
        logic [63:0] npc;
        logic [10:0] shs;
        logic [7:0]  tt;
    } exp_t;

    exp_t sb[$];

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [10:0] rcv_hs(input logic [10:0] h);
        return (h | 11'h024) & ~11'h401;
    endfunction

    task automatic do_trap(input logic [7:0] tt, input logic rec, input logic hyp,
                           input logic [2:0] tl, input logic [12:0] ps, input logic [10:0] hs,
                           input logic [7:0] cc, input logic [7:0] asi, input logic [2:0] win,
                           input logic [2:0] free, input logic [2:0] gl,
                           input logic [63:0] pc, input logic [63:0] npc);
        exp_t e;
        int   w;
        int   cap;
        @(negedge clk);
        trap_type = tt; sel_recover = rec; sel_hyp = hyp; cur_tl = tl; cur_ps = ps;
        cur_hs = hs; cur_cc = cc; cur_asi = asi; cur_win = win; cur_free = free;
        cur_gl = gl; cur_pc = pc; cur_npc = npc; trap_req = 1'b1;
        e.tl = tl + 3'd1;                                       // R1
        if (rec) begin                                          // R5
            e.ps = (ps & 13'h004) | 13'h010;
            e.hs = rcv_hs(hs);
        end else if (hyp) begin                                 // R6
            e.ps = (ps | 13'h010) & ~13'h20A;
            e.hs = (hs & ~11'h420) | 11'h004;
        end else begin                                          // R7
            e.ps = ((ps | 13'h014) & ~13'h20A) | (ps[8] ? 13'h200 : 13'h000);
            e.hs = hs;
        end
        cap = (rec || hyp) ? 3 : 2;                             // R8
        e.gl = (int'(gl) + 1 > cap) ? 3'(cap) : 3'(int'(gl) + 1);
        e.wwe = 1'b1;                                           // R9
        if (tt == 8'h24) w = int'(win) + 1;
        else if (tt >= 8'h80 && tt <= 8'hBF) w = int'(win) + int'(free) + 2;
        else if (tt >= 8'hC0) w = int'(win) + 7;
        else begin w = int'(win); e.wwe = 1'b0; end
        e.win  = 3'(w % 8);
        e.word = {gl, cc, asi, 3'b000, ps, 3'b000, 2'b00, win}; // R3
        e.pc   = ps[3] ? {32'h0, pc[31:0]}  : pc;               // R2
        e.npc  = ps[3] ? {32'h0, npc[31:0]} : npc;
        e.shs  = hs;                                            // R4
        e.tt   = tt;
        sb.push_back(e);
        @(negedge clk);
        trap_req = 1'b0;
    endtask

    // monitor
    always @(negedge clk) begin
        if (!rst && done) begin
            if (sb.size() == 0) begin
                chk("R1", "done without request", 64'd1, 64'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk("R1", "new_tl", 64'(new_tl), 64'(e.tl));
                chk("R5/R6/R7", "new_ps", 64'(new_ps), 64'(e.ps));
                chk("R5/R6/R7", "new_hs", 64'(new_hs), 64'(e.hs));
                chk("R8", "new_gl", 64'(new_gl), 64'(e.gl));
                chk("R9", "new_win", 64'(new_win), 64'(e.win));
                chk("R9", "win_we", 64'(win_we), 64'(e.wwe));
                chk("R3", "stk_word", 64'(stk_word), 64'(e.word));
                chk("R2", "stk_pc", stk_pc, e.pc);
                chk("R2", "stk_npc", stk_npc, e.npc);
                chk("R4", "stk_hs", 64'(stk_hs), 64'(e.shs));
                chk("R4", "stk_tt", 64'(stk_tt), 64'(e.tt));
                chk("R4", "stk_we", 64'(stk_we), 64'h1f);
            end
        end
    end

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        chk("WDOG", "timeout", 64'd1, 64'd0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1; por_req = 1'b0; trap_req = 1'b0; trap_type = '0; sel_recover = 1'b0;
        sel_hyp = 1'b0; cur_tl = '0; cur_ps = '0; cur_hs = '0; cur_cc = '0; cur_asi = '0;
        cur_win = '0; cur_free = '0; cur_gl = '0; cur_pc = '0; cur_npc = '0;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11", "done", 64'(done), 64'd0);
        chk("R11", "new_tl", 64'(new_tl), 64'd0);
        chk("R11", "stk_word", 64'(stk_word), 64'd0);
        chk("R11", "tick_lock", 64'(tick_lock), 64'd0);
        chk("R11", "stk_we", 64'(stk_we), 64'd0);
        rst = 1'b0;
        @(negedge clk);

        // recovery, 0x24 wraps 7->0, address masking
        do_trap(8'h24, 1'b1, 1'b1, 3'd1, 13'h1FFF, 11'h7FF, 8'hA5, 8'h3C, 3'd7, 3'd2, 3'd1,
                64'hDEAD_BEEF_1234_5678, 64'hDEAD_BEEF_1234_567C);
        // hyperprivileged, spill range, window 5+3+2 wraps to 2, GL saturates at 3
        do_trap(8'h85, 1'b0, 1'b1, 3'd2, 13'h0FFF & ~13'h008 | 13'h200, 11'h001, 8'h11, 8'h22,
                3'd5, 3'd3, 3'd3, 64'hFFFF_0000_0000_1000, 64'hFFFF_0000_0000_1004);
        // privileged, fill range, 0 wraps to 7, tle copied into cle
        do_trap(8'hC0, 1'b0, 1'b0, 3'd0, 13'h010A, 11'h420, 8'h5A, 8'hC3, 3'd0, 3'd1, 3'd1,
                64'h0000_0001_0000_2000, 64'h0000_0001_0000_2004);
        // privileged, GL already at privileged cap, window unchanged
        do_trap(8'h10, 1'b0, 1'b0, 3'd3, 13'h0208, 11'h024, 8'h00, 8'hFF, 3'd4, 3'd0, 3'd2,
                64'h8000_0000_0000_0040, 64'h8000_0000_0000_0044);
        // privileged entry from GL above the privileged cap
        do_trap(8'h30, 1'b0, 1'b0, 3'd4, 13'h0000, 11'h000, 8'h01, 8'h02, 3'd6, 3'd0, 3'd3,
                64'h10, 64'h14);
        // hyperprivileged, top of fill range, tlz preserved, cle cleared
        do_trap(8'hFF, 1'b0, 1'b1, 3'd5, 13'h0302, 11'h401, 8'h77, 8'h88, 3'd3, 3'd0, 3'd0,
                64'h20, 64'h24);
        // recovery, top of spill range: 1+7+2=10 -> 2
        do_trap(8'hBF, 1'b1, 1'b0, 3'd6, 13'h0000, 11'h3DE, 8'h9C, 8'h4B, 3'd1, 3'd7, 3'd2,
                64'h0000_0000_FFFF_FFF0, 64'h0000_0000_FFFF_FFF4);
        @(negedge clk);
        @(negedge clk);
        chk("R1", "queue drained", 64'(sb.size()), 64'd0);
        chk("R1", "done idle", 64'(done), 64'd0);

        // power-on load
        cur_hs = 11'h7DB;
        por_req = 1'b1;
        @(negedge clk);
        por_req = 1'b0;
        chk("R10", "new_tl", 64'(new_tl), 64'd6);
        chk("R10", "new_gl", 64'(new_gl), 64'd3);
        chk("R10", "new_ps", 64'(new_ps), 64'h014);
        chk("R10", "new_hs", 64'(new_hs), 64'(rcv_hs(11'h7DB)));
        chk("R10", "tick_lock", 64'(tick_lock), 64'd1);
        chk("R10", "done", 64'(done), 64'd0);
        chk("R10", "stk_we", 64'(stk_we), 64'd0);

        // power-on colliding with a trap
        cur_tl = 3'd1; cur_gl = 3'd0; trap_type = 8'h24; trap_req = 1'b1; por_req = 1'b1;
        @(negedge clk);
        trap_req = 1'b0; por_req = 1'b0;
        chk("R10", "collide done", 64'(done), 64'd0);
        chk("R10", "collide tl", 64'(new_tl), 64'd6);
        chk("R10", "collide win_we", 64'(win_we), 64'd0);
        @(negedge clk);
        chk("R10", "lock sticky", 64'(tick_lock), 64'd1);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule